// File: doc/BRIEF.md
# Multi-Channel Edge Capture Arbiter

This block merges timing events from a group of eight channels into a single stream of write operations towards a shared 256-entry first-level buffer. Each channel delivers a strobe, an edge flag and a time word. The block adds a programmable offset to every recorded time. In one of the modes it pairs a leading edge with the following trailing edge, and the resulting pulse width can later correct time walk.

Each channel keeps up to four pending measurements in its own small queue. A round-robin arbiter takes at most one entry per cycle from the queues and presents it on the write port as a channel number, an edge kind, a time and a width. The downstream buffer reports when it is full. While it is full, nothing is granted, the queues keep their contents, and a sticky error flag is raised. Hits that reach a full queue are lost and counted per channel.

Top module: `edge_merge_arbiter`

## Requirements
- R1: With `cfg_mode` = 0 only leading edges (`hit_trail` = 0) are recorded, as kind 0. Trailing edges produce no entry.
- R2: With `cfg_mode` = 1 only trailing edges are recorded, as kind 1. Leading edges produce no entry.
- R3: With `cfg_mode` = 3 both edges are recorded as separate entries, kind 0 for leading and kind 1 for trailing, in arrival order.
- R4: With `cfg_mode` = 2 a leading edge is held. The next trailing edge on the same channel yields one kind 2 entry whose time is the held leading time and whose width is trailing time minus leading time, modulo 2^16. Entries of any other kind carry width 0.
- R5: In `cfg_mode` = 2 a width above 255 is written as 255.
- R6: In `cfg_mode` = 2 a trailing edge with no held leading edge produces no entry, and a second leading edge replaces the held one.
- R7: Every written time equals the raw time plus `cfg_offset`, modulo 2^16.
- R8: A strobe sampled at clock edge k appears on the write port (`wr_en` high) right after edge k+1, and not before. The kind code 3 is never written.
- R9: Each channel queue holds 4 entries. A hit that finds its queue full is dropped and adds one to that channel's 8-bit overflow count, which saturates at 255.
- R10: Grants rotate round-robin, starting the search at the channel after the last one granted (channel 0 first after reset).
- R11: While `buf_full` is high no write is issued and queued entries are kept. `full_err` is set when `buf_full` is high while any queue holds data, and it stays set until reset.
- R12: After reset `wr_en`, `full_err` and all overflow counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 leading, 1 trailing, 2 paired width, 3 both edges |
| cfg_offset | input | 16 | Offset added to recorded times |
| hit_stb | input | 8 | Per-channel event strobe |
| hit_trail | input | 8 | Per-channel edge flag, 1 = trailing |
| hit_time | input | 128 | Per-channel 16-bit time, channel c at bits [16c+15:16c] |
| buf_full | input | 1 | Shared buffer cannot take a write |
| wr_en | output | 1 | Write strobe to the shared buffer |
| wr_chan | output | 3 | Channel number of the entry |
| wr_kind | output | 2 | Edge kind: 0 leading, 1 trailing, 2 pair |
| wr_time | output | 16 | Corrected time |
| wr_width | output | 8 | Pulse width (pair entries only) |
| full_err | output | 1 | Sticky: stall seen with data pending |
| ovf_cnt | output | 64 | Per-channel drop counts, channel c at bits [8c+7:8c] |

## Verification
The hardest situation to reach is a channel queue overflowing, because the arbiter normally empties a queue as fast as one channel can fill it. The bench therefore holds `buf_full` high so that nothing drains. It then fires more hits than the queue depth, and later hundreds more to reach counter saturation. The same stall is used to preload several queues at once, so that releasing it exposes the round-robin order, which starts from a known last grant.

// File: rtl/edge_merge_arbiter.sv
module edge_merge_arbiter #(
  parameter int NCH = 8,
  parameter int TW  = 16,
  parameter int WW  = 8,
  parameter int QD  = 4,
  parameter int OVW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_mode,
  input  logic [TW-1:0]        cfg_offset,
  input  logic [NCH-1:0]       hit_stb,
  input  logic [NCH-1:0]       hit_trail,
  input  logic [NCH*TW-1:0]    hit_time,
  input  logic                 buf_full,
  output logic                 wr_en,
  output logic [$clog2(NCH)-1:0] wr_chan,
  output logic [1:0]           wr_kind,
  output logic [TW-1:0]        wr_time,
  output logic [WW-1:0]        wr_width,
  output logic                 full_err,
  output logic [NCH*OVW-1:0]   ovf_cnt
);
  localparam int CW = $clog2(NCH);
  localparam int PW = $clog2(QD);
  localparam int QW = $clog2(QD + 1);
  localparam int EW = 2 + TW + WW;
  localparam logic [1:0] K_LEAD = 2'd0, K_TRAIL = 2'd1, K_PAIR = 2'd2;

  logic [EW-1:0]  head   [NCH];
  logic [NCH-1:0] nonempty;
  logic           gnt_vld;
  logic [CW-1:0]  gsel, last;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [EW-1:0]  mem [QD];
    logic [PW-1:0]  rd, wr;
    logic [QW-1:0]  cnt;
    logic           lead_vld;
    logic [TW-1:0]  lead_raw;
    logic [OVW-1:0] ovf;
    logic           want, push, drop, pop;
    logic [1:0]     kind;
    logic [TW-1:0]  tm;
    logic [WW-1:0]  wd;

    wire [TW-1:0] t    = hit_time[c*TW +: TW];
    wire [TW-1:0] diff = t - lead_raw;
    wire [WW-1:0] wsat = (|diff[TW-1:WW]) ? '1 : diff[WW-1:0];
    wire          trl  = hit_trail[c];

    always_comb begin
      want = 1'b0;
      kind = K_LEAD;
      tm   = t + cfg_offset;
      wd   = '0;
      if (hit_stb[c]) begin
        case (cfg_mode)
          2'd0: want = !trl;
          2'd1: begin want = trl; kind = K_TRAIL; end
          2'd2: if (trl && lead_vld) begin
                  want = 1'b1;
                  kind = K_PAIR;
                  tm   = lead_raw + cfg_offset;
                  wd   = wsat;
                end
          default: begin want = 1'b1; kind = trl ? K_TRAIL : K_LEAD; end
        endcase
      end
    end

    assign push        = want && (cnt != QW'(QD));
    assign drop        = want && (cnt == QW'(QD));
    assign pop         = gnt_vld && (gsel == CW'(c));
    assign nonempty[c] = (cnt != '0);
    assign head[c]     = mem[rd];
    assign ovf_cnt[c*OVW +: OVW] = ovf;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd <= '0; wr <= '0; cnt <= '0;
        lead_vld <= 1'b0; lead_raw <= '0; ovf <= '0;
        for (int i = 0; i < QD; i++) mem[i] <= '0;
      end else begin
        if (push) begin
          mem[wr] <= {kind, tm, wd};
          wr <= wr + 1'b1;
        end
        if (pop) rd <= rd + 1'b1;
        if (push && !pop) cnt <= cnt + 1'b1;
        else if (pop && !push) cnt <= cnt - 1'b1;
        if (drop && ovf != '1) ovf <= ovf + 1'b1;
        if (hit_stb[c] && cfg_mode == 2'd2) begin
          lead_vld <= !trl;
          if (!trl) lead_raw <= t;
        end
      end
    end
  end

  always_comb begin
    logic [CW-1:0] idx;
    gnt_vld = 1'b0;
    gsel    = last;
    idx     = '0;
    for (int i = 1; i <= NCH; i++) begin
      idx = last + CW'(i);
      if (!gnt_vld && !buf_full && nonempty[idx]) begin
        gnt_vld = 1'b1;
        gsel    = idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en <= 1'b0; wr_chan <= '0; wr_kind <= '0; wr_time <= '0; wr_width <= '0;
      last <= CW'(NCH - 1);
      full_err <= 1'b0;
    end else begin
      wr_en <= gnt_vld;
      if (gnt_vld) begin
        wr_chan <= gsel;
        {wr_kind, wr_time, wr_width} <= head[gsel];
        last <= gsel;
      end
      if (buf_full && |nonempty) full_err <= 1'b1;
    end
  end
endmodule

// File: rtl/edge_merge_arbiter_chk.sv
module edge_merge_arbiter_chk #(
  parameter int NCH = 8,
  parameter int WW  = 8,
  parameter int OVW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               buf_full,
  input logic               wr_en,
  input logic [1:0]         wr_kind,
  input logic [WW-1:0]      wr_width,
  input logic               full_err,
  input logic [NCH*OVW-1:0] ovf_cnt
);
  // R11
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n) buf_full |=> !wr_en);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) full_err |=> full_err);
  // R8
  kind_code_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> wr_kind != 2'd3);
  // R4
  width_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind != 2'd2) |-> wr_width == '0);
  for (genvar c = 0; c < NCH; c++) begin : g_ovf
    // R9
    ovf_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ovf_cnt[c*OVW +: OVW] >= $past(ovf_cnt[c*OVW +: OVW]));
  end
endmodule

bind edge_merge_arbiter edge_merge_arbiter_chk #(.NCH(NCH), .WW(WW), .OVW(OVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_full(buf_full), .wr_en(wr_en), .wr_kind(wr_kind),
  .wr_width(wr_width), .full_err(full_err), .ovf_cnt(ovf_cnt)
);

// File: tb/edge_merge_arbiter_bench.sv
`timescale 1ns/1ps
module edge_merge_arbiter_bench;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  cfg_mode = 0;
  logic [15:0] cfg_offset = 0;
  logic [7:0]  hit_stb = 0, hit_trail = 0;
  logic [127:0] hit_time = 0;
  logic        buf_full = 0;
  logic        wr_en, full_err;
  logic [2:0]  wr_chan;
  logic [1:0]  wr_kind;
  logic [15:0] wr_time;
  logic [7:0]  wr_width;
  logic [63:0] ovf_cnt;

  int total = 0, bad = 0, n = 0;
  logic [28:0] lg [64];
  bit done = 0;

  always #4 clk = ~clk;

  edge_merge_arbiter u_edge_merge_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_offset(cfg_offset),
    .hit_stb(hit_stb), .hit_trail(hit_trail), .hit_time(hit_time), .buf_full(buf_full),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_kind(wr_kind), .wr_time(wr_time),
    .wr_width(wr_width), .full_err(full_err), .ovf_cnt(ovf_cnt));

  always @(negedge clk) if (rst_n && wr_en && n < 64) begin
    lg[n] = {wr_chan, wr_kind, wr_time, wr_width};
    n++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ent(input string tag, input int idx, input int ch, input int k,
                         input int t, input int w);
    chk(tag, (idx < n) ? {3'd0, lg[idx]} : 32'hffff_ffff,
        {3'd0, ch[2:0], k[1:0], t[15:0], w[7:0]});
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic hit(input int ch, input bit tr, input logic [15:0] t);
    @(negedge clk);
    hit_stb = '0; hit_stb[ch] = 1'b1; hit_trail[ch] = tr; hit_time[ch*16 +: 16] = t;
    @(negedge clk);
    hit_stb = '0;
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [15:0] off);
    @(negedge clk);
    rst_n = 0; buf_full = 0; hit_stb = '0; cfg_mode = m; cfg_offset = off;
    idle(2);
    rst_n = 1;
    idle(1);
  endtask

  task automatic t_reset;
    do_reset(2'd0, 16'd0);
    chk("R12 wr_en", wr_en, 0);
    chk("R12 full_err", full_err, 0);
    chk("R12 ovf", ovf_cnt[31:0] | ovf_cnt[63:32], 0);
  endtask

  task automatic t_latency;
    do_reset(2'd0, 16'd0);
    @(negedge clk);
    hit_stb[6] = 1; hit_trail[6] = 0; hit_time[6*16 +: 16] = 16'd77;
    @(negedge clk);
    hit_stb = '0;
    chk("R8 not early", wr_en, 0);
    @(negedge clk);
    chk("R8 on time", {wr_en, wr_chan, wr_time}, {1'b1, 3'd6, 16'd77});
  endtask

  task automatic t_lead;
    int b;
    do_reset(2'd0, 16'd10);
    b = n;
    hit(3, 0, 100); hit(3, 1, 200); idle(4);
    chk("R1 count", n - b, 1);
    chk_ent("R1 lead entry", b, 3, 0, 110, 0);
  endtask

  task automatic t_trail;
    int b;
    do_reset(2'd1, 16'd10);
    b = n;
    hit(5, 0, 300); hit(5, 1, 400); idle(4);
    chk("R2 count", n - b, 1);
    chk_ent("R2 trail entry", b, 5, 1, 410, 0);
  endtask

  task automatic t_both;
    int b;
    do_reset(2'd3, 16'd10);
    b = n;
    hit(1, 0, 50); hit(1, 1, 70); idle(4);
    chk("R3 count", n - b, 2);
    chk_ent("R3 first", b, 1, 0, 60, 0);
    chk_ent("R3 second", b + 1, 1, 1, 80, 0);
  endtask

  task automatic t_pair;
    int b;
    do_reset(2'd2, 16'd10);
    b = n;
    hit(2, 1, 5); idle(3);
    chk("R6 lone trailing", n - b, 0);
    hit(2, 0, 100); hit(2, 0, 120); hit(2, 1, 150); idle(4);
    chk("R6 count", n - b, 1);
    chk_ent("R4 pair", b, 2, 2, 130, 30);
    b = n;
    hit(2, 0, 1000); hit(2, 1, 1400); idle(4);
    chk_ent("R5 saturate", b, 2, 2, 1010, 255);
    b = n;
    cfg_offset = 16'd20;
    hit(2, 0, 16'd65530); hit(2, 1, 16'd20); idle(4);
    chk_ent("R7 wrap", b, 2, 2, 14, 26);
  endtask

  task automatic t_rr;
    int b;
    do_reset(2'd0, 16'd0);
    hit(7, 0, 9); idle(3);
    @(negedge clk); buf_full = 1;
    b = n;
    hit(5, 0, 500); hit(2, 0, 200); hit(0, 0, 1); hit(0, 0, 2); idle(4);
    chk("R11 no write", n - b, 0);
    chk("R11 full_err", full_err, 1);
    buf_full = 0;
    idle(8);
    chk("R10 count", n - b, 4);
    chk_ent("R10 first", b, 0, 0, 1, 0);
    chk_ent("R10 second", b + 1, 2, 0, 200, 0);
    chk_ent("R10 third", b + 2, 5, 0, 500, 0);
    chk_ent("R10 fourth", b + 3, 0, 0, 2, 0);
    chk("R11 sticky", full_err, 1);
  endtask

  task automatic t_ovf;
    int b;
    do_reset(2'd0, 16'd0);
    @(negedge clk); buf_full = 1;
    b = n;
    for (int i = 0; i < 6; i++) hit(4, 0, 16'(10 + i));
    idle(2);
    chk("R9 ovf ch4", ovf_cnt[39:32], 2);
    chk("R9 ovf others", ovf_cnt[31:0] | ovf_cnt[63:40], 0);
    buf_full = 0;
    idle(8);
    chk("R9 kept", n - b, 4);
    chk_ent("R9 oldest", b, 4, 0, 10, 0);
    chk_ent("R9 newest", b + 3, 4, 0, 13, 0);
    buf_full = 1;
    for (int i = 0; i < 304; i++) begin
      @(negedge clk);
      hit_stb[4] = 1; hit_trail[4] = 0; hit_time[4*16 +: 16] = 16'(i);
    end
    @(negedge clk); hit_stb = '0;
    idle(2);
    chk("R9 saturate", ovf_cnt[39:32], 255);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_lead();
    t_trail();
    t_both();
    t_pair();
    t_rr();
    t_ovf();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule